// File: doc/BRIEF.md
# User/Supervisor Bank Remapping Controller

This block is glue logic placed beside a processor that drives a 16-bit address on dedicated pins. The processor puts the upper address byte (the bank) on its 8-bit data bus during the low half of its bus clock. The block captures that byte and joins it to the 16-bit address to form a 24-bit physical address. It also keeps a privilege state. In supervisor mode the processor's own bank byte reaches memory unchanged. In user mode that byte is discarded and a bank register, loaded by supervisor code, is used instead. A user process, including its stack and direct-page data, is therefore confined to one 64K bank.

The privilege state is derived only from bus strobes. A falling edge on the active-low vector-pull strobe marks an interrupt entry: it switches to supervisor mode and raises a nesting depth. An RTI opcode fetch lowers the depth. When an RTI brings the depth to zero, or arrives while it is already zero, the block returns to user mode. A user-mode access to the hardware register page raises a violation flag, which external logic can use to abort the access.

The whole block runs on one fast system clock. The processor's bus clock phase, strobes and data bus are sampled once per system clock.

Top module: `bank_guard`

## Requirements
- R1: While `cpu_phase_i` is low, `phys_addr_o[23:16]` in supervisor mode equals `cpu_data_i` combinationally. While the phase is high, it holds the byte captured at the last system clock edge at which the phase was sampled low.
- R2: In supervisor mode (`user_mode_o` = 0), `phys_addr_o` is {captured bank byte, `cpu_addr_i[15:0]`}.
- R3: In user mode (`user_mode_o` = 1), `phys_addr_o[23:16]` equals the user-bank register whatever the data bus carries, and `phys_addr_o[15:0]` equals `cpu_addr_i`.
- R4: A high-to-low change of `vp_n_i` between two clock samples forces supervisor mode from the next edge on and adds one to the nesting depth. Holding `vp_n_i` low for several cycles counts as a single entry.
- R5: An RTI fetch is `cpu_vda_i` = 1, `cpu_vpa_i` = 1, `cpu_phase_i` = 1 and `cpu_data_i` = 8'h40. Each high phase showing it lowers the depth by one, however many clocks the phase lasts.
- R6: An RTI fetch that leaves the depth at zero switches to user mode at the next edge. An RTI fetch at depth zero keeps the depth at zero, so a single later vector pull followed by a single RTI returns to user mode. A vector pull in the same cycle as an RTI fetch takes priority.
- R7: The depth is 4 bits wide and saturates at 15. After 16 or more entries, exactly 15 RTI fetches are needed to reach user mode.
- R8: `violation_o` = 1 exactly when the block is in user mode, `cpu_vda_i` or `cpu_vpa_i` is 1, and `cpu_addr_i[15:8]` equals the register page 8'hFE.
- R9: `ubank_we_i` loads `ubank_data_i` into the user-bank register only in supervisor mode. In user mode the write is ignored.
- R10: After reset the block is in supervisor mode with depth 0, the captured bank 8'h00 and the user-bank register 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the processor bus clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cpu_phase_i | input | 1 | Processor bus clock phase (1 = high phase) |
| cpu_data_i | input | 8 | Processor data bus; carries the bank byte during the low phase |
| cpu_addr_i | input | 16 | Processor 16-bit address |
| cpu_vda_i | input | 1 | Valid data address strobe |
| cpu_vpa_i | input | 1 | Valid program address strobe |
| vp_n_i | input | 1 | Vector-pull strobe, active low |
| ubank_we_i | input | 1 | Write strobe for the user-bank register |
| ubank_data_i | input | 8 | Value for the user-bank register |
| phys_addr_o | output | 24 | Physical address: bank byte and 16-bit address |
| user_mode_o | output | 1 | 1 = user mode, 0 = supervisor mode |
| violation_o | output | 1 | User-mode access to the hardware register page |

## Verification
The nesting depth is not visible at the ports. A wrong depth therefore appears only later, when `user_mode_o` changes on the wrong RTI: one fetch too early if the counter wrapped or double-counted, or never if it stuck. The bench counts RTI fetches one by one and checks the mode after each. A faulty bank capture or remap appears at once on `phys_addr_o[23:16]`, within one system clock of a phase change. A mode error also shows on `violation_o` during the same cycle as the register-page access.

// File: rtl/bg_pkg.sv
package bg_pkg;

  localparam logic [7:0] RTI_OPCODE = 8'h40;

  // Saturating increment and floor-at-zero decrement of the nesting depth.
  function automatic int unsigned depth_up(int unsigned cur, int unsigned max_v);
    return (cur >= max_v) ? max_v : cur + 1;
  endfunction

  function automatic int unsigned depth_down(int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Opcode fetch of the return-from-interrupt instruction.
  function automatic logic is_rti_fetch(logic vda, logic vpa, logic phase, logic [7:0] bus);
    return vda && vpa && phase && (bus == RTI_OPCODE);
  endfunction

endpackage

// File: rtl/bg_bank_capture.sv
module bg_bank_capture #(
  parameter int BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);

  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       bank_q <= '0;
    else if (!phase_i) bank_q <= data_i;
  end

  // Transparent while the phase is low, holding once it goes high.
  assign bank_o = phase_i ? bank_q : data_i;

  // R1: a high phase freezes the captured byte
  assert_bank_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> $stable(bank_q));

endmodule

// File: rtl/bg_priv_tracker.sv
module bg_priv_tracker
  import bg_pkg::*;
#(
  parameter int DEPTH_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vp_n_i,
  input  logic              vda_i,
  input  logic              vpa_i,
  input  logic              phase_i,
  input  logic [7:0]        data_i,
  output logic              user_mode_o,
  output logic [DEPTH_W-1:0] depth_o
);

  localparam int unsigned DEPTH_MAX = (1 << DEPTH_W) - 1;

  logic               vp_n_q, rti_seen_q;
  logic               vp_fall, rti_now, rti_pulse;
  logic               user_q, user_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;

  assign vp_fall   = vp_n_q && !vp_n_i;
  assign rti_now   = is_rti_fetch(vda_i, vpa_i, phase_i, data_i);
  assign rti_pulse = rti_now && !rti_seen_q;

  always_comb begin
    user_d  = user_q;
    depth_d = depth_q;
    if (vp_fall) begin
      user_d  = 1'b0;
      depth_d = DEPTH_W'(depth_up(int'(depth_q), DEPTH_MAX));
    end else if (rti_pulse) begin
      depth_d = DEPTH_W'(depth_down(int'(depth_q)));
      if (depth_d == '0) user_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vp_n_q     <= 1'b1;
      rti_seen_q <= 1'b0;
      user_q     <= 1'b0;
      depth_q    <= '0;
    end else begin
      vp_n_q     <= vp_n_i;
      rti_seen_q <= rti_now;
      user_q     <= user_d;
      depth_q    <= depth_d;
    end
  end

  assign user_mode_o = user_q;
  assign depth_o     = depth_q;

  // R4: an interrupt entry always lands in supervisor mode
  assert_vp_enters_sup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vp_fall |=> !user_q);

  // R5: a fetch held across several clocks is counted once
  assert_rti_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_now && rti_seen_q && !vp_fall) |=> $stable(depth_q));

  // R6: the last matching RTI returns to user mode
  assert_rti_to_user_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rti_pulse && !vp_fall && depth_q <= DEPTH_W'(1)) |=> (user_q && depth_q == '0));

  // R7: the depth never wraps past its ceiling
  assert_depth_saturates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vp_fall && depth_q == DEPTH_W'(DEPTH_MAX)) |=> (depth_q == DEPTH_W'(DEPTH_MAX)));

endmodule

// File: rtl/bg_access_guard.sv
module bg_access_guard #(
  parameter int          ADDR_W   = 16,
  parameter int          BANK_W   = 8,
  parameter logic [7:0]  REG_PAGE = 8'hFE
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     user_mode_i,
  input  logic [BANK_W-1:0]        cpu_bank_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     vda_i,
  input  logic                     vpa_i,
  input  logic                     we_i,
  input  logic [BANK_W-1:0]        wdata_i,
  output logic [BANK_W+ADDR_W-1:0] phys_o,
  output logic                     violation_o
);

  logic [BANK_W-1:0] ubank_q;
  logic              reg_page_hit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                   ubank_q <= '0;
    else if (we_i && !user_mode_i) ubank_q <= wdata_i;
  end

  assign reg_page_hit = (addr_i[ADDR_W-1:ADDR_W-8] == REG_PAGE);
  assign phys_o       = {(user_mode_i ? ubank_q : cpu_bank_i), addr_i};
  assign violation_o  = user_mode_i && (vda_i || vpa_i) && reg_page_hit;

  // R9: user code cannot move its own bank
  assert_ubank_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_i |=> $stable(ubank_q));

  // R8: supervisor accesses never flag
  assert_no_sup_violation_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_mode_i |-> !violation_o);

endmodule

// File: rtl/bank_guard.sv
module bank_guard #(
  parameter int         ADDR_W   = 16,
  parameter int         BANK_W   = 8,
  parameter int         DEPTH_W  = 4,
  parameter logic [7:0] REG_PAGE = 8'hFE
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cpu_phase_i,
  input  logic [7:0]               cpu_data_i,
  input  logic [ADDR_W-1:0]        cpu_addr_i,
  input  logic                     cpu_vda_i,
  input  logic                     cpu_vpa_i,
  input  logic                     vp_n_i,
  input  logic                     ubank_we_i,
  input  logic [BANK_W-1:0]        ubank_data_i,
  output logic [BANK_W+ADDR_W-1:0] phys_addr_o,
  output logic                     user_mode_o,
  output logic                     violation_o
);

  logic [BANK_W-1:0]  cpu_bank;
  logic [DEPTH_W-1:0] depth;
  logic               user_mode;

  bg_bank_capture #(.BANK_W(BANK_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (cpu_phase_i),
    .data_i  (cpu_data_i[BANK_W-1:0]),
    .bank_o  (cpu_bank)
  );

  bg_priv_tracker #(.DEPTH_W(DEPTH_W)) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vp_n_i      (vp_n_i),
    .vda_i       (cpu_vda_i),
    .vpa_i       (cpu_vpa_i),
    .phase_i     (cpu_phase_i),
    .data_i      (cpu_data_i),
    .user_mode_o (user_mode),
    .depth_o     (depth)
  );

  bg_access_guard #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_PAGE(REG_PAGE)) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .user_mode_i (user_mode),
    .cpu_bank_i  (cpu_bank),
    .addr_i      (cpu_addr_i),
    .vda_i       (cpu_vda_i),
    .vpa_i       (cpu_vpa_i),
    .we_i        (ubank_we_i),
    .wdata_i     (ubank_data_i),
    .phys_o      (phys_addr_o),
    .violation_o (violation_o)
  );

  assign user_mode_o = user_mode;

  // R6: user mode is only ever held with no interrupt outstanding
  assert_user_implies_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode |-> (depth == '0));

  // R2: supervisor mode keeps the low address untouched
  assert_low_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[ADDR_W-1:0] == cpu_addr_i);

endmodule

// File: tb/test_bank_guard.sv
`timescale 1ns/1ps
module test_bank_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase = 1'b1;
  logic [7:0]  data = 8'h00;
  logic [15:0] addr = 16'h0000;
  logic        vda = 1'b0, vpa = 1'b0, vp_n = 1'b1;
  logic        we = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [23:0] phys;
  logic        user, viol;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  bank_guard i_bank_guard (
    .clk_i(clk), .rst_ni(rst_n), .cpu_phase_i(phase), .cpu_data_i(data),
    .cpu_addr_i(addr), .cpu_vda_i(vda), .cpu_vpa_i(vpa), .vp_n_i(vp_n),
    .ubank_we_i(we), .ubank_data_i(wdata), .phys_addr_o(phys),
    .user_mode_o(user), .violation_o(viol)
  );

  // {bank byte, 16-bit address}
  localparam logic [23:0] VEC [6] = '{
    24'h00_1234, 24'h01_FFFF, 24'h7F_0000, 24'h80_8001, 24'hFF_FE10, 24'hA5_5A5A
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic vector_pull();
    vp_n = 1'b0; tick(); tick();
    vp_n = 1'b1; tick();
  endtask

  task automatic rti(int hold);
    phase = 1'b1; vda = 1'b1; vpa = 1'b1; data = 8'h40;
    for (int k = 0; k < hold; k++) tick();
    phase = 1'b0; vda = 1'b0; vpa = 1'b0; data = 8'h00;
    tick();
    phase = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    data = 8'hC3;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R10: reset state
    check("R10 mode", {31'd0, user}, 32'd0);
    check("R10 bank", {8'd0, phys}, {8'd0, 8'h00, 16'h0000});
    addr = 16'hFE00; vda = 1'b1;
    check("R10 no violation", {31'd0, viol}, 32'd0);
    vda = 1'b0;

    // R1/R2 vector table in supervisor mode
    foreach (VEC[i]) begin
      phase = 1'b0; data = VEC[i][23:16]; addr = VEC[i][15:0];
      #0.1;
      check("R1 transparent", {8'd0, phys}, {8'd0, VEC[i]});
      tick();
      phase = 1'b1; data = ~VEC[i][23:16];
      #0.1;
      check("R2 held pass-through", {8'd0, phys}, {8'd0, VEC[i]});
      tick();
      check("R1 hold across high phase", {8'd0, phys}, {8'd0, VEC[i]});
    end

    // R9: supervisor write of the user bank
    we = 1'b1; wdata = 8'h37; tick(); we = 1'b0;

    // R6: RTI at depth zero enters user mode
    rti(1);
    check("R6 rti at zero -> user", {31'd0, user}, 32'd1);

    // R3: remapped bank in both phases
    phase = 1'b0; data = 8'h99; addr = 16'h0100; #0.1;
    check("R3 user bank low phase", {8'd0, phys}, {8'd0, 24'h37_0100});
    tick(); phase = 1'b1; data = 8'h12; #0.1;
    check("R3 user bank high phase", {8'd0, phys}, {8'd0, 24'h37_0100});

    // R9: user write ignored
    we = 1'b1; wdata = 8'h55; tick(); we = 1'b0; tick();
    check("R9 user write ignored", {24'd0, phys[23:16]}, 32'h37);

    // R8: violation cases
    addr = 16'hFE22; vda = 1'b1; #0.1;
    check("R8 user reg access", {31'd0, viol}, 32'd1);
    vda = 1'b0; vpa = 1'b1; #0.1;
    check("R8 user reg fetch", {31'd0, viol}, 32'd1);
    vpa = 1'b0; #0.1;
    check("R8 no strobe", {31'd0, viol}, 32'd0);
    addr = 16'hFD22; vda = 1'b1; #0.1;
    check("R8 other page", {31'd0, viol}, 32'd0);
    vda = 1'b0;

    // R4: vector pull back to supervisor, long pull counts once
    vector_pull();
    check("R4 vp -> supervisor", {31'd0, user}, 32'd0);
    addr = 16'hFE22; vda = 1'b1; #0.1;
    check("R8 supervisor no violation", {31'd0, viol}, 32'd0);
    vda = 1'b0;
    vector_pull();                       // depth 2
    rti(3);                              // R5: held fetch counts once -> depth 1
    check("R5 held rti counted once", {31'd0, user}, 32'd0);
    rti(1);
    check("R4 nested return -> user", {31'd0, user}, 32'd1);

    // R7: saturation at 15
    for (int n = 0; n < 20; n++) vector_pull();
    for (int n = 0; n < 14; n++) rti(1);
    check("R7 still supervisor after 14", {31'd0, user}, 32'd0);
    rti(1);
    check("R7 user after 15", {31'd0, user}, 32'd1);

    // R6: extra RTI at zero does not wrap
    rti(1);
    check("R6 rti at zero stays user", {31'd0, user}, 32'd1);
    vector_pull();
    rti(1);
    check("R6 depth stayed zero", {31'd0, user}, 32'd1);

    // R6: vector pull wins over a simultaneous RTI fetch
    phase = 1'b1; vda = 1'b1; vpa = 1'b1; data = 8'h40; vp_n = 1'b0;
    tick();
    vda = 1'b0; vpa = 1'b0; data = 8'h00; vp_n = 1'b1;
    tick();
    check("R6 vp priority", {31'd0, user}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule